// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a byte-addressed serial memory that sits on a two-wire bus (clock plus open-drain data). It runs on the system clock. The bus clock and data lines are oversampled through two-flop synchronizers, and start, stop and clock edges are found on the synchronized copies. The block recognises its own device byte, takes in a two-byte word address, and hands each received data byte to a separate write engine as a one-cycle strobe that carries an address and a byte. It answers current-address, random and sequential reads from a byte array, and that array takes the same write strobes.

The slave never drives the data line high. It only pulls it low, through `sda_pull_o`, for acknowledges and for the 0 bits of read data. A busy input from the write engine silences the slave. While busy is high it acknowledges nothing, not even a matching device byte, so a master can poll until an internal write has finished.

Top module: `ee2w_slave`

## Requirements
- R1: SDA falling while SCL is high is a start condition. It begins a new transaction in any state and the bus is released. SDA rising while SCL is high is a stop condition, which returns the slave to idle with the bus released.
- R2: The device byte arrives MSB first. It matches when bits 7..3 are 10100 and bits 2..1 equal `dev_sel_i`. Bit 0 selects the direction (1 = read, 0 = write). On a match the slave pulls SDA low throughout the ninth clock.
- R3: On a mismatch the slave gives no acknowledge, produces no write strobes and ignores all clocks until the next start.
- R4: While `busy_i` is high when a byte completes, that byte is not acknowledged, even if it is a matching device byte, and no write strobe is produced.
- R5: A write-direction device byte is followed by a high and then a low word-address byte, and both are acknowledged. The word address counter loads the low ADDR_W bits of {high, low}, and the upper bits are ignored.
- R6: Each data byte after the address is acknowledged and emitted as one `wr_valid_o` pulse carrying `wr_addr_o` and `wr_data_o`. The address then advances only in its low PAGE_W bits, so it wraps to the start of the same page.
- R7: Read data goes out MSB first: a 0 bit is pulled low and a 1 bit is released. A current-address read returns the byte at the counter, which holds the last accessed address plus one and keeps that value between transactions.
- R8: A random read is a write-direction address phase with no data, followed by a repeated start and a read device byte. It returns the byte at the loaded address.
- R9: A master acknowledge after a read byte makes the slave send the byte at the next address. A master no-acknowledge ends the read, and the slave releases SDA until a start or stop.
- R10: During reads the address wraps from 2^ADDR_W-1 to 0.
- R11: `sda_pull_o` changes only while SCL is low (start and stop excepted).
- R12: After reset `sda_pull_o` and `wr_valid_o` are low.
- R13: Bytes delivered through `wr_valid_o` are stored in the array and are returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| dev_sel_i | input | 2 | Hardwired device select bits |
| busy_i | input | 1 | Write engine busy; suppresses all acknowledges |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| wr_valid_o | output | 1 | One-cycle write byte strobe |
| wr_addr_o | output | ADDR_W | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |

## Verification
Two functions can fall in the same cycle. The busy check and the device-address compare are both decided on the eighth rising clock edge of the device byte. The bench raises busy before a fully matching write device byte and follows it with data. It judges the outcome by the sampled acknowledge and by the absence of any write strobe in the scoreboard. The second collision is the sequential-read increment at the array's last address, where the increment and the wrap happen together. A read that begins at the top address is acknowledged into the next byte, and the value returned must be the byte stored at address 0.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD, ST_WAIT
  } ee2w_state_e;

  localparam logic [4:0] DEV_PREFIX = 5'b10100;
  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/ee2w_line_sync.sv
module ee2w_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign rise_o  = scl_o & ~scl_d;
  assign fall_o  = ~scl_o & scl_d;
  // sda transitions while scl held high are framing, never data
  assign start_o = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/ee2w_store.sv
module ee2w_store #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        dev_sel_i,
  input  logic              busy_i,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS - 1);
  localparam logic [3:0] ACK_BIT  = 4'(BYTE_BITS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;

  ee2w_line_sync #(.STAGES(2)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_o   (scl_s),
    .sda_o   (sda_s),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall),
    .start_o (start_w),
    .stop_o  (stop_w)
  );

  ee2w_state_e       state_q, next_q;
  logic [7:0]        sh_q, hi_q;
  logic [3:0]        bit_q;
  logic              ack_ph_q, mack_q, oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        rd_data;
  logic [7:0]        rx_byte;
  logic [15:0]       word_addr;
  logic              dev_hit, rx_state;

  assign rx_byte   = {sh_q[6:0], sda_s};
  assign word_addr = {hi_q, rx_byte};
  assign dev_hit   = (rx_byte[7:3] == DEV_PREFIX) && (rx_byte[2:1] == dev_sel_i);
  assign rx_state  = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                     (state_q == ST_ALO) || (state_q == ST_WR);

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  ee2w_store #(.ADDR_W(ADDR_W)) i_store (
    .clk_i   (clk_i),
    .we_i    (wr_valid_o),
    .waddr_i (wr_addr_o),
    .wdata_i (wr_data_o),
    .raddr_i (addr_q),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      next_q     <= ST_IDLE;
      sh_q       <= '0;
      hi_q       <= '0;
      bit_q      <= '0;
      ack_ph_q   <= 1'b0;
      mack_q     <= 1'b0;
      oe_q       <= 1'b0;
      addr_q     <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (start_w) begin
        state_q  <= ST_DEV;
        bit_q    <= '0;
        ack_ph_q <= 1'b0;
        oe_q     <= 1'b0;
      end else if (stop_w) begin
        state_q  <= ST_IDLE;
        bit_q    <= '0;
        ack_ph_q <= 1'b0;
        oe_q     <= 1'b0;
      end else if (rx_state) begin
        if (!ack_ph_q) begin
          if (scl_rise && bit_q != ACK_BIT) begin
            sh_q  <= rx_byte;
            bit_q <= bit_q + 4'd1;
            if (bit_q == LAST_BIT) begin
              if (busy_i || (state_q == ST_DEV && !dev_hit)) begin
                state_q <= ST_WAIT;
              end else begin
                unique case (state_q)
                  ST_DEV: next_q <= rx_byte[0] ? ST_RD : ST_AHI;
                  ST_AHI: begin
                    hi_q   <= rx_byte;
                    next_q <= ST_ALO;
                  end
                  ST_ALO: begin
                    addr_q <= word_addr[ADDR_W-1:0];
                    next_q <= ST_WR;
                  end
                  default: begin
                    wr_valid_o <= 1'b1;
                    wr_addr_o  <= addr_q;
                    wr_data_o  <= rx_byte;
                    addr_q     <= page_next(addr_q);
                    next_q     <= ST_WR;
                  end
                endcase
              end
            end
          end else if (scl_fall && bit_q == ACK_BIT) begin
            ack_ph_q <= 1'b1;
            oe_q     <= 1'b1;
          end
        end else if (scl_fall) begin
          ack_ph_q <= 1'b0;
          bit_q    <= '0;
          state_q  <= next_q;
          if (next_q == ST_RD) begin
            sh_q   <= rd_data;
            oe_q   <= ~rd_data[7];
            addr_q <= addr_q + ADDR_W'(1);
          end else begin
            oe_q <= 1'b0;
          end
        end
      end else if (state_q == ST_RD) begin
        if (!ack_ph_q) begin
          if (scl_rise) begin
            bit_q <= bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == ACK_BIT) begin
              ack_ph_q <= 1'b1;
              oe_q     <= 1'b0;
            end else begin
              sh_q <= {sh_q[6:0], 1'b0};
              oe_q <= ~sh_q[6];
            end
          end
        end else if (scl_rise) begin
          mack_q <= ~sda_s;
        end else if (scl_fall) begin
          ack_ph_q <= 1'b0;
          bit_q    <= '0;
          if (mack_q) begin
            sh_q   <= rd_data;
            oe_q   <= ~rd_data[7];
            addr_q <= addr_q + ADDR_W'(1);
          end else begin
            state_q <= ST_WAIT;
            oe_q    <= 1'b0;
          end
        end
      end
    end
  end

  assign sda_pull_o = oe_q;

  AST_PULL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) && !$past(start_w) && !$past(stop_w) |-> !scl_s); // R11
  AST_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (state_q == ST_DEV) && !sda_pull_o); // R1
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w && !start_w |=> (state_q == ST_IDLE) && !sda_pull_o); // R1
  AST_WR_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> state_q == ST_WR); // R6
  AST_ADDR_HELD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && $past(state_q == ST_IDLE) |-> $stable(addr_q)); // R7
  AST_NO_PULL_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) && $past(state_q == ST_WAIT) |-> !sda_pull_o); // R3
endmodule

// File: tb/test_ee2w_slave.sv
`timescale 1ns/1ps
module test_ee2w_slave;
  localparam int ADDR_W = 10;
  localparam int PAGE_W = 6;
  localparam int Q = 8;
  localparam logic [1:0] PINS = 2'b10;
  localparam logic [7:0] DEV_W = {5'b10100, PINS, 1'b0};
  localparam logic [7:0] DEV_R = {5'b10100, PINS, 1'b1};

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic [7:0]        d;
  } wr_item_t;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic pull, wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;
  wire sda = m_sda & ~pull;

  int total = 0, bad = 0, pull_viol = 0;
  bit done = 1'b0;
  wr_item_t exp_q[$];

  ee2w_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ee2w_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .dev_sel_i(PINS),
    .busy_i(busy), .sda_pull_o(pull), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        chk("R3/R4/R6", "unexpected strobe addr", {22'd0, wr_addr}, 32'hFFFF_FFFF);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        chk("R6", "strobe addr", {22'd0, wr_addr}, {22'd0, e.a});
        chk("R6", "strobe data", {24'd0, wr_data}, {24'd0, e.d});
      end
    end
  end

  logic pull_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && pull != pull_prev && scl) pull_viol++;
    pull_prev = pull;
  end

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
    end
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q / 2);
    ack = ~sda;
    tick(Q / 2); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q / 2); b[i] = sda; tick(Q / 2); scl = 1'b0;
    end
    m_sda = ~give_ack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; m_sda = 1'b1;
  endtask

  task automatic push_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_item_t e;
    e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    tick(4);
    chk("R12", "pull after reset", {31'd0, pull}, 0);
    chk("R12", "strobe after reset", {31'd0, wr_valid}, 0);
    rst_n = 1'b1; tick(8);

    // page write, high address bits ignored: 0xF93E -> 0x13E, wraps within page
    bus_start();
    send_byte(DEV_W, ack); chk("R2", "dev ack", {31'd0, ack}, 1);
    send_byte(8'hF9, ack); chk("R5", "addr hi ack", {31'd0, ack}, 1);
    send_byte(8'h3E, ack); chk("R5", "addr lo ack", {31'd0, ack}, 1);
    push_wr(10'h13E, 8'h81); send_byte(8'h81, ack); chk("R6", "data0 ack", {31'd0, ack}, 1);
    push_wr(10'h13F, 8'h42); send_byte(8'h42, ack); chk("R6", "data1 ack", {31'd0, ack}, 1);
    push_wr(10'h100, 8'hC3); send_byte(8'hC3, ack); chk("R6", "data2 ack", {31'd0, ack}, 1);
    push_wr(10'h101, 8'h18); send_byte(8'h18, ack); chk("R6", "data3 ack", {31'd0, ack}, 1);
    bus_stop(); tick(Q);
    chk("R1", "released after stop", {31'd0, pull}, 0);

    // random + sequential read over the page wrap result
    bus_start();
    send_byte(DEV_W, ack); send_byte(8'h01, ack); send_byte(8'h00, ack);
    chk("R8", "dummy addr ack", {31'd0, ack}, 1);
    bus_start();
    send_byte(DEV_R, ack); chk("R8", "read dev ack", {31'd0, ack}, 1);
    recv_byte(1'b1, rb); chk("R8", "random byte 0x100", {24'd0, rb}, 32'hC3);
    recv_byte(1'b0, rb); chk("R9", "seq byte 0x101", {24'd0, rb}, 32'h18);
    tick(Q); chk("R9", "released after nack", {31'd0, pull}, 0);
    bus_stop();

    // data for wrap and current-address checks
    bus_start();
    send_byte(DEV_W, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    push_wr(10'h000, 8'h3C); send_byte(8'h3C, ack);
    push_wr(10'h001, 8'h5A); send_byte(8'h5A, ack);
    bus_stop();
    bus_start();
    send_byte(DEV_W, ack); send_byte(8'h03, ack); send_byte(8'hFF, ack);
    push_wr(10'h3FF, 8'hA5); send_byte(8'hA5, ack);
    bus_stop();

    // read wrap top -> 0
    bus_start();
    send_byte(DEV_W, ack); send_byte(8'h03, ack); send_byte(8'hFF, ack);
    bus_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b1, rb); chk("R13", "top byte", {24'd0, rb}, 32'hA5);
    recv_byte(1'b0, rb); chk("R10", "wrapped byte 0", {24'd0, rb}, 32'h3C);
    bus_stop();

    // current-address read: counter persisted at 0x001
    tick(4 * Q);
    bus_start();
    send_byte(DEV_R, ack); chk("R7", "current dev ack", {31'd0, ack}, 1);
    recv_byte(1'b0, rb); chk("R7", "current byte 0x001", {24'd0, rb}, 32'h5A);
    bus_stop();

    // select mismatch and prefix mismatch
    bus_start();
    send_byte({5'b10100, 2'b01, 1'b0}, ack); chk("R3", "select mismatch ack", {31'd0, ack}, 0);
    send_byte(8'h00, ack); chk("R3", "ignored byte ack", {31'd0, ack}, 0);
    send_byte(8'h00, ack); send_byte(8'hEE, ack);
    chk("R3", "ignored data ack", {31'd0, ack}, 0);
    bus_stop();
    bus_start();
    send_byte({5'b10110, PINS, 1'b1}, ack); chk("R3", "prefix mismatch ack", {31'd0, ack}, 0);
    bus_stop();

    // busy coincides with a matching device byte
    busy = 1'b1;
    bus_start();
    send_byte(DEV_W, ack); chk("R4", "busy dev ack", {31'd0, ack}, 0);
    send_byte(8'h00, ack); send_byte(8'h00, ack); send_byte(8'h77, ack);
    chk("R4", "busy data ack", {31'd0, ack}, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(DEV_W, ack); chk("R4", "dev ack after busy", {31'd0, ack}, 1);
    send_byte(8'h00, ack); send_byte(8'h00, ack);
    bus_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b0, rb); chk("R4", "byte 0 untouched by busy write", {24'd0, rb}, 32'h3C);
    bus_stop();

    tick(4 * Q);
    chk("R6", "strobes outstanding", exp_q.size(), 0);
    chk("R11", "pull changes while SCL high", pull_viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule